// File: doc/BRIEF.md
# Memory Controller Interrupt Aggregator

This block gathers the three interrupt causes of an external memory controller onto one interrupt request line. One cause is an error pulse from the controller's own ECC checker, which is already synchronous to the block clock. The other two are asynchronous pins: the NAND flash busy/ready line and a general-purpose interrupt input from the programmable fabric. Each asynchronous pin passes through a synchronizer. The block reacts to the pin's low-to-high transition, not to its level.

Every cause is caught in a sticky status bit. A separate enable register decides which status bits may drive the shared interrupt line. Software reads the status register to find which cause fired. It then writes ones to the same register to acknowledge those causes. A small register port with an address, a write strobe, write data and combinational read data gives access to both registers.

Top module: `mem_irq_agg`

## Requirements
- R1: A clock edge with `rstN` low clears the status and enable registers and drives `irqOut` low. Reads of both registers then return zero.
- R2: A rising transition on `nandBusyPin` sets status bit 1. The bit becomes readable after the third rising clock edge that samples the pin high. A pin held high sets the bit only once.
- R3: A rising transition on `fabricIrqPin` sets status bit 2 with the same latency and single-shot behaviour as R2.
- R4: `eccEvent` high at a clock edge sets status bit 0 at that edge.
- R5: Status bits are sticky. A write to address 0 clears exactly the bits whose write-data bit is 1. Zero bits in the write data, and writes to other addresses, leave the status unchanged.
- R6: When an event arrives in the same cycle as a write that clears its bit, the bit stays set.
- R7: A write to address 1 loads the enable register from write-data bits [2:0]. Address 0 reads status and address 1 reads enable, both in bits [2:0]. Every other bit and every other address reads zero.
- R8: `irqOut` is a registered signal. It goes high one clock edge after any status bit and its matching enable bit are both 1, and it goes low one edge after no such pair remains.
- R9: A status bit set while its enable bit is 0 still reads back as 1, and `irqOut` stays low.
- R10: A falling transition on either external pin never sets a status bit.
- R11: If a pin is already high while `rstN` is low and stays high after reset is released, no status bit is set for that pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| eccEvent | input | 1 | Synchronous ECC error pulse |
| nandBusyPin | input | 1 | Asynchronous NAND busy/ready pin |
| fabricIrqPin | input | 1 | Asynchronous fabric interrupt pin |
| regAddr | input | ADDR_W | Register address, 0 status, 1 enable |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Combinational register read data |
| irqOut | output | 1 | Shared interrupt request |

## Verification
Several properties are checked on every cycle: status bits stay set unless a write clears them, an event always leaves its bit set, each detected edge lasts exactly one cycle, no edge appears right after reset, reset empties both registers, and the interrupt line rises only when an enabled status bit was present. Other behaviour appears only in the bench scenarios. This covers the exact three-edge latency of the pin path, the one-shot response to a held pin, the lack of response to falling pins, and the read-back of raw status with its enable off. It also covers the address decode and the mix of random writes, clears and pin activity, all compared against a cycle model built from the requirements.

// File: rtl/mem_irq_pkg.sv
package mem_irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_ECC  = 0;
  localparam int SRC_NAND = 1;
  localparam int SRC_FAB  = 2;
  localparam int NUM_EXT  = 2;

  typedef struct packed {
    logic               clrStatus;
    logic               ldEnable;
    logic               selStatus;
    logic               selEnable;
    logic [NUM_SRC-1:0] evt;
  } irqStrobe_t;
endpackage

// File: rtl/mem_irq_ctrl.sv
module mem_irq_ctrl
  import mem_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_ADDR = 0,
  parameter int ENABLE_ADDR = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEvent,
  input  logic              nandBusyPin,
  input  logic              fabricIrqPin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output irqStrobe_t        stb
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [NUM_EXT-1:0] extPins;
  logic [NUM_EXT-1:0] extEdge;

  assign extPins = {fabricIrqPin, nandBusyPin};

  for (genvar g = 0; g < NUM_EXT; g++) begin : g_pin
    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
      if (!rstN) chain <= {CHAIN_W{extPins[g]}};
      else       chain <= {chain[CHAIN_W-2:0], extPins[g]};
    end

    assign extEdge[g] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // R2/R3: a detected edge is a single-cycle pulse
    p_single_edge_r2: assert property (@(posedge clk) disable iff (!rstN)
      extEdge[g] |=> !extEdge[g]);
  end

  // R11: history preloaded at reset, so no edge on the first cycle out of reset
  p_no_edge_after_reset_r11: assert property (@(posedge clk)
    $rose(rstN) |-> (extEdge == '0));

  always_comb begin
    stb.evt            = '0;
    stb.evt[SRC_ECC]   = eccEvent;
    stb.evt[SRC_NAND]  = extEdge[0];
    stb.evt[SRC_FAB]   = extEdge[1];
    stb.selStatus      = (regAddr == ADDR_W'(STATUS_ADDR));
    stb.selEnable      = (regAddr == ADDR_W'(ENABLE_ADDR));
    stb.clrStatus      = regWrEn && stb.selStatus;
    stb.ldEnable       = regWrEn && stb.selEnable;
  end
endmodule

// File: rtl/mem_irq_dp.sv
module mem_irq_dp
  import mem_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobe_t        stb,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [NUM_SRC-1:0] clearMask;
  logic [NUM_SRC-1:0] keepMask;
  logic [NUM_SRC-1:0] statusD;

  assign clearMask = stb.clrStatus ? regWrData[NUM_SRC-1:0] : '0;
  assign keepMask  = statusQ & ~clearMask;
  assign statusD   = keepMask | stb.evt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      irqOut  <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (stb.ldEnable) enableQ <= regWrData[NUM_SRC-1:0];
      irqOut  <= |(statusQ & enableQ);
    end
  end

  always_comb begin
    regRdData = '0;
    if (stb.selStatus)      regRdData[NUM_SRC-1:0] = statusQ;
    else if (stb.selEnable) regRdData[NUM_SRC-1:0] = enableQ;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (statusQ == '0 && enableQ == '0 && !irqOut));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (keepMask != '0) |=> ((statusQ & $past(keepMask)) == $past(keepMask)));

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.evt != '0) |=> ((statusQ & $past(stb.evt)) == $past(stb.evt)));

  p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past((statusQ & enableQ) != '0));
endmodule

// File: rtl/mem_irq_agg.sv
module mem_irq_agg
  import mem_irq_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEvent,
  input  logic              nandBusyPin,
  input  logic              fabricIrqPin,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  irqStrobe_t stb;

  mem_irq_ctrl #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .STATUS_ADDR(0), .ENABLE_ADDR(1)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .eccEvent(eccEvent), .nandBusyPin(nandBusyPin),
    .fabricIrqPin(fabricIrqPin), .regAddr(regAddr), .regWrEn(regWrEn), .stb(stb)
  );

  mem_irq_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/mem_irq_agg_bench.sv
module mem_irq_agg_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       eccEvent = 1'b0, nandBusyPin = 1'b0, fabricIrqPin = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       irqOut;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [2:0] stE, enE, hN, hF;
  logic       irqE;

  always #2 clk = ~clk;

  mem_irq_agg u_mem_irq_agg (
    .clk(clk), .rstN(rstN), .eccEvent(eccEvent), .nandBusyPin(nandBusyPin),
    .fabricIrqPin(fabricIrqPin), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [7:0] expRead(input logic [1:0] a, input logic [2:0] s,
                                         input logic [2:0] e);
    if (a == 2'd0) return {5'd0, s};
    if (a == 2'd1) return {5'd0, e};
    return 8'd0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic step(input logic rst, input logic ecc, input logic nand_, input logic fab,
                      input logic we, input logic [1:0] a, input logic [7:0] d,
                      input string tag);
    logic [2:0] ev;
    rstN = ~rst; eccEvent = ecc; nandBusyPin = nand_; fabricIrqPin = fab;
    regWrEn = we; regAddr = a; regWrData = d;
    @(posedge clk);
    if (rst) begin
      stE = 0; enE = 0; irqE = 0; hN = {3{nand_}}; hF = {3{fab}};
    end else begin
      ev = {hF[1] & ~hF[2], hN[1] & ~hN[2], ecc};
      irqE = |(stE & enE);
      if (we && a == 2'd0) stE = (stE & ~d[2:0]) | ev;
      else                 stE = stE | ev;
      if (we && a == 2'd1) enE = d[2:0];
      hN = {hN[1:0], nand_};
      hF = {hF[1:0], fab};
    end
    @(negedge clk);
    regWrEn = 1'b0;
    check(regRdData == expRead(regAddr, stE, enE), tag, regRdData, expRead(regAddr, stE, enE));
    check(irqOut == irqE, {tag, " R8 irq"}, irqOut, irqE);
  endtask

  task automatic idle(input int n, input logic nand_, input logic fab, input logic [1:0] a,
                      input string tag);
    for (int i = 0; i < n; i++) step(0, 0, nand_, fab, 0, a, 0, tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0, 0, "R1 reset");
    step(0, 0, 0, 0, 0, 2'd0, 0, "R1 status zero");
    step(0, 0, 0, 0, 0, 2'd1, 0, "R1 enable zero");

    // R4: ecc pulse
    step(0, 1, 0, 0, 0, 2'd0, 0, "R4 ecc set");
    check(regRdData == 8'h01, "R4 bit0", regRdData, 1);
    // R5: write zero bits, other address, then clear
    step(0, 0, 0, 0, 1, 2'd0, 8'hFE, "R5 zero bits keep");
    step(0, 0, 0, 0, 1, 2'd3, 8'hFF, "R5 other addr");
    step(0, 0, 0, 0, 0, 2'd0, 0, "R5 read");
    check(regRdData == 8'h01, "R5 sticky", regRdData, 1);
    step(0, 0, 0, 0, 1, 2'd0, 8'h01, "R5 clear");
    check(regRdData == 8'h00, "R5 cleared", regRdData, 0);

    // R2: nand rise latency, held high one-shot
    step(0, 0, 1, 0, 0, 2'd0, 0, "R2 edge1");
    step(0, 0, 1, 0, 0, 2'd0, 0, "R2 edge2");
    check(regRdData == 8'h00, "R2 not yet", regRdData, 0);
    step(0, 0, 1, 0, 0, 2'd0, 0, "R2 edge3");
    check(regRdData == 8'h02, "R2 set at third edge", regRdData, 2);
    step(0, 0, 1, 0, 1, 2'd0, 8'h02, "R2 clear");
    idle(6, 1, 0, 2'd0, "R2 held high");
    check(regRdData == 8'h00, "R2 one-shot", regRdData, 0);
    // R10: falling edges
    idle(6, 0, 0, 2'd0, "R10 falling");
    check(regRdData == 8'h00, "R10 no set", regRdData, 0);

    // R3 and R9: fabric with enable off, then enable it
    idle(4, 0, 1, 2'd0, "R3 fabric");
    check(regRdData == 8'h04, "R3 bit2", regRdData, 4);
    check(irqOut == 1'b0, "R9 irq low disabled", irqOut, 0);
    step(0, 0, 0, 1, 1, 2'd1, 8'h04, "R7 enable fab");
    check(regRdData == 8'h04, "R7 enable read", regRdData, 4);
    step(0, 0, 0, 1, 0, 2'd1, 0, "R8 irq rise");
    check(irqOut == 1'b1, "R8 irq high", irqOut, 1);
    step(0, 0, 0, 0, 1, 2'd0, 8'h04, "R8 clear");
    step(0, 0, 0, 0, 0, 2'd2, 0, "R7 addr2 zero");
    check(irqOut == 1'b0, "R8 irq low", irqOut, 0);

    // R6: event same cycle as clear
    step(0, 1, 0, 0, 1, 2'd0, 8'h07, "R6 event wins");
    check(regRdData == 8'h01, "R6 kept", regRdData, 1);

    // R11: pins high through reset
    for (int i = 0; i < 3; i++) step(1, 0, 1, 1, 0, 0, 0, "R11 reset high");
    idle(6, 1, 1, 2'd0, "R11 held");
    check(regRdData == 8'h00, "R11 no false edge", regRdData, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(0, r[0] & r[1] & r[2], r[3] ^ (r[4] & nandBusyPin), r[5] ^ (r[6] & fabricIrqPin),
           (r[9:7] == 3'd0), r[11:10], r[19:12], "R5/R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule